// File: doc/BRIEF.md
# Keyboard and Display Bus Port

This block sits on a shared synchronous register bus, inside the same address space as memory, so ordinary load and store cycles reach it. It serves one character input device and one character output device. A decoder recognises three register addresses above a configurable base: a key-data register, a display-data register and a combined status/control register. Any other address leaves the block untouched.

Ready flags coordinate the processor with the slow devices. A character arriving from the keyboard side is latched and raises an input-ready flag. Reading the key-data register drops that flag. A processor write to the display-data register hands the character to the display side and drops the output-ready flag. The display side raises the flag again with a done pulse. If a new key arrives before the previous one was read, the data is overwritten and a sticky overrun bit is set. A status read clears that bit.

Each ready flag is gated by its own software-writable enable bit to form a per-device interrupt request. The two requests are also ORed onto one line.

Top module: `kbd_disp_port`

## Requirements
- R1: Registers live at BASE+0 (key data, read only), BASE+1 (display data, read returns the last byte written) and BASE+2 (status/control). A write to any other address, or to the key-data register, changes no state. A read of any other address returns 0.
- R2: A cycle with key_valid high latches key_char into the key-data register and sets input-ready (status bit 0) from the next cycle.
- R3: Reading the key-data register returns the latched character and clears input-ready, unless key_valid is high in that same cycle. In that case input-ready stays 1 and no overrun is recorded.
- R4: key_valid while input-ready is 1, without a same-cycle key-data read, overwrites the data and sets the sticky overrun bit (status bit 6). A status read returns the overrun bit and then clears it.
- R5: A write to the display-data register loads bus_wdata into disp_char, pulses disp_load for exactly one cycle after the write, and clears output-ready (status bit 1).
- R6: A disp_done pulse sets output-ready. If a display-data write falls in the same cycle, the write wins and output-ready ends at 0.
- R7: Status bits 2 (keyboard interrupt enable) and 3 (display interrupt enable) are read/write. Writes to every other status bit are ignored.
- R8: kbd_irq equals input-ready AND keyboard enable, and dsp_irq equals output-ready AND display enable. Both are mirrored in status bits 4 and 5. irq is their OR.
- R9: Reset clears both ready flags, both enables, overrun, disp_load, every interrupt output and bus_rdata.
- R10: bus_rdata is registered. It shows the addressed value in the cycle after the read strobe and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Registered read data |
| key_valid | input | 1 | Keyboard side presents a new character |
| key_char | input | CHAR_W | Character from the keyboard side |
| disp_char | output | CHAR_W | Character handed to the display |
| disp_load | output | 1 | One-cycle pulse: disp_char is new |
| disp_done | input | 1 | Display can accept another character |
| kbd_irq | output | 1 | Keyboard interrupt request |
| dsp_irq | output | 1 | Display interrupt request |
| irq | output | 1 | Combined interrupt request |

## Verification
Flag, enable and interrupt changes appear right after the clock edge that captures the stimulus. disp_load is high for the single cycle after the write edge. bus_rdata carries the read result one edge after the strobe. The bench drives every stimulus on a falling edge and samples on the next falling edge, so each sample lands one register stage after its cause. The scoreboard pairs each queued read expectation with the falling edge that follows the capturing rising edge.

// File: rtl/kdp_pkg.sv
package kdp_pkg;
   localparam int unsigned OFS_W    = 2;
   localparam int unsigned NREG     = 3;
   localparam int unsigned REG_KEY  = 0;
   localparam int unsigned REG_DSP  = 1;
   localparam int unsigned REG_STAT = 2;

   // status layout, low bit first: in_rdy, out_rdy, kie, die, kirq, dirq, ovr
   typedef struct packed {
      logic ovr;
      logic dirq;
      logic kirq;
      logic die;
      logic kie;
      logic out_rdy;
      logic in_rdy;
   } kdp_stat_t;

   localparam int unsigned ST_W   = $bits(kdp_stat_t);
   localparam int unsigned ST_KIE = 2;
   localparam int unsigned ST_DIE = 3;
endpackage

// File: rtl/kdp_addr_dec.sv
module kdp_addr_dec
   import kdp_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [NREG-1:0]   sel
);
   logic base_hit;

   if (ADDR_W <= OFS_W) begin : g_bad_addr_w
      $error("kdp_addr_dec: ADDR_W too small");
   end
   if (BASE_ADDR[OFS_W-1:0] != '0) begin : g_bad_base
      $error("kdp_addr_dec: BASE_ADDR not aligned");
   end

   assign base_hit = (addr[ADDR_W-1:OFS_W] == BASE_ADDR[ADDR_W-1:OFS_W]);

   for (genvar g = 0; g < NREG; g++) begin : g_sel
      assign sel[g] = base_hit && (addr[OFS_W-1:0] == OFS_W'(g));
   end
endmodule

// File: rtl/kdp_kbd_chan.sv
module kdp_kbd_chan #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_char,
   input  logic              rd_key,
   input  logic              rd_stat,
   input  logic              wr_ie,
   input  logic              ie_d,
   output logic [CHAR_W-1:0] key_q,
   output logic              in_rdy,
   output logic              ovr,
   output logic              kie
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         key_q  <= '0;
         in_rdy <= 1'b0;
         ovr    <= 1'b0;
         kie    <= 1'b0;
      end else begin
         if (key_valid) key_q <= key_char;

         if (key_valid)   in_rdy <= 1'b1;
         else if (rd_key) in_rdy <= 1'b0;

         if (key_valid && in_rdy && !rd_key) ovr <= 1'b1;
         else if (rd_stat)                   ovr <= 1'b0;

         if (wr_ie) kie <= ie_d;
      end
   end

   p_set_rdy_r2: assert property (@(posedge clk) disable iff (!rst_n)
      key_valid |=> in_rdy);
   p_clr_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_key && !key_valid) |=> !in_rdy);
   p_ovr_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (key_valid && in_rdy && !rd_key) |=> ovr);
   p_ovr_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr && !rd_stat) |=> ovr);
endmodule

// File: rtl/kdp_dsp_chan.sv
module kdp_dsp_chan #(
   parameter int unsigned CHAR_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_dsp,
   input  logic [CHAR_W-1:0] wchar,
   input  logic              disp_done,
   input  logic              wr_ie,
   input  logic              ie_d,
   output logic [CHAR_W-1:0] disp_char,
   output logic              disp_load,
   output logic              out_rdy,
   output logic              die
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         disp_char <= '0;
         disp_load <= 1'b0;
         out_rdy   <= 1'b0;
         die       <= 1'b0;
      end else begin
         disp_load <= wr_dsp;
         if (wr_dsp) disp_char <= wchar;

         if (wr_dsp)         out_rdy <= 1'b0;
         else if (disp_done) out_rdy <= 1'b1;

         if (wr_ie) die <= ie_d;
      end
   end

   p_load_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dsp |=> disp_load);
   p_rdy_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      wr_dsp |=> !out_rdy);
   p_done_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (disp_done && !wr_dsp) |=> out_rdy);
endmodule

// File: rtl/kdp_rd_path.sv
module kdp_rd_path #(
   parameter int unsigned BUS_W    = 8,
   parameter bit          READ_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rd_en,
   input  logic [BUS_W-1:0] rd_word,
   output logic [BUS_W-1:0] rdata
);
   if (READ_REG) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)     rdata <= '0;
         else if (rd_en) rdata <= rd_word;
      end

      p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
         !rd_en |=> $stable(rdata));
   end else begin : g_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rdata = rd_en ? rd_word : '0;
   end
endmodule

// File: rtl/kbd_disp_port.sv
module kbd_disp_port
   import kdp_pkg::*;
#(
   parameter int unsigned       ADDR_W    = 16,
   parameter int unsigned       BUS_W     = 8,
   parameter int unsigned       CHAR_W    = 8,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h4000,
   parameter bit                READ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic              key_valid,
   input  logic [CHAR_W-1:0] key_char,
   output logic [CHAR_W-1:0] disp_char,
   output logic              disp_load,
   input  logic              disp_done,
   output logic              kbd_irq,
   output logic              dsp_irq,
   output logic              irq
);
   if (BUS_W < ST_W) begin : g_bad_bus_w
      $error("kbd_disp_port: BUS_W narrower than status");
   end
   if (CHAR_W > BUS_W || CHAR_W == 0) begin : g_bad_char_w
      $error("kbd_disp_port: CHAR_W out of range");
   end

   logic [NREG-1:0]   sel;
   logic              rd_key, rd_stat, wr_dsp, wr_stat;
   logic [CHAR_W-1:0] key_q;
   logic              in_rdy, out_rdy, ovr, kie, die;
   kdp_stat_t         st;
   logic [BUS_W-1:0]  rd_word;

   kdp_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
      .addr (bus_addr),
      .sel  (sel)
   );

   assign rd_key  = bus_rd && sel[REG_KEY];
   assign rd_stat = bus_rd && sel[REG_STAT];
   assign wr_dsp  = bus_wr && sel[REG_DSP];
   assign wr_stat = bus_wr && sel[REG_STAT];

   kdp_kbd_chan #(.CHAR_W(CHAR_W)) u_kbd (
      .clk       (clk),
      .rst_n     (rst_n),
      .key_valid (key_valid),
      .key_char  (key_char),
      .rd_key    (rd_key),
      .rd_stat   (rd_stat),
      .wr_ie     (wr_stat),
      .ie_d      (bus_wdata[ST_KIE]),
      .key_q     (key_q),
      .in_rdy    (in_rdy),
      .ovr       (ovr),
      .kie       (kie)
   );

   kdp_dsp_chan #(.CHAR_W(CHAR_W)) u_dsp (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_dsp    (wr_dsp),
      .wchar     (bus_wdata[CHAR_W-1:0]),
      .disp_done (disp_done),
      .wr_ie     (wr_stat),
      .ie_d      (bus_wdata[ST_DIE]),
      .disp_char (disp_char),
      .disp_load (disp_load),
      .out_rdy   (out_rdy),
      .die       (die)
   );

   assign kbd_irq = in_rdy && kie;
   assign dsp_irq = out_rdy && die;
   assign irq     = kbd_irq || dsp_irq;

   always_comb begin
      st         = '0;
      st.in_rdy  = in_rdy;
      st.out_rdy = out_rdy;
      st.kie     = kie;
      st.die     = die;
      st.kirq    = kbd_irq;
      st.dirq    = dsp_irq;
      st.ovr     = ovr;
   end

   always_comb begin
      rd_word = '0;
      if (sel[REG_KEY])  rd_word = BUS_W'(key_q);
      if (sel[REG_DSP])  rd_word = BUS_W'(disp_char);
      if (sel[REG_STAT]) rd_word = BUS_W'(st);
   end

   kdp_rd_path #(.BUS_W(BUS_W), .READ_REG(READ_REG)) u_rd (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_en   (bus_rd),
      .rd_word (rd_word),
      .rdata   (bus_rdata)
   );

   p_sel_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(sel));
   p_ie_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_stat |=> ($stable(kie) && $stable(die)));
endmodule

// File: tb/kbd_disp_port_tb_top.sv
`timescale 1ns/1ps
module kbd_disp_port_tb_top;
   localparam int unsigned ADDR_W = 16;
   localparam int unsigned BUS_W  = 8;
   localparam int unsigned CHAR_W = 8;
   localparam logic [15:0] BASE   = 16'h4000;
   localparam logic [15:0] A_KEY  = BASE + 16'd0;
   localparam logic [15:0] A_DSP  = BASE + 16'd1;
   localparam logic [15:0] A_ST   = BASE + 16'd2;

   logic clk = 1'b0;
   always #10 clk = ~clk;

   logic              rst_n = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic              bus_rd = 1'b0, bus_wr = 1'b0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;
   logic              key_valid = 1'b0;
   logic [CHAR_W-1:0] key_char = '0;
   logic [CHAR_W-1:0] disp_char;
   logic              disp_load;
   logic              disp_done = 1'b0;
   logic              kbd_irq, dsp_irq, irq;

   kbd_disp_port #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .CHAR_W(CHAR_W),
                   .BASE_ADDR(BASE)) dut_i (
      .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
      .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .key_valid(key_valid), .key_char(key_char), .disp_char(disp_char),
      .disp_load(disp_load), .disp_done(disp_done), .kbd_irq(kbd_irq),
      .dsp_irq(dsp_irq), .irq(irq)
   );

   int total = 0;
   int bad   = 0;
   bit fin   = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];
   logic       rd_seen = 1'b0;
   logic [7:0] m_exp;
   string      m_tag;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [7:0] stw(input bit inr, input bit outr, input bit kie,
                                      input bit die, input bit ovr);
      return {1'b0, ovr, outr & die, inr & kie, die, kie, outr, inr};
   endfunction

   // monitor: each read strobe captured at a rising edge is compared at the next falling edge
   always @(posedge clk) rd_seen <= bus_rd;
   always @(negedge clk) begin
      if (rd_seen && exp_q.size() > 0) begin
         m_exp = exp_q.pop_front();
         m_tag = tag_q.pop_front();
         chk(m_tag, 32'(bus_rdata), 32'(m_exp));
      end
   end

   task automatic bus_read(input logic [15:0] a, input logic [7:0] e, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_addr = a; bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic read_with_key(input logic [15:0] a, input logic [7:0] e,
                                input logic [7:0] ch, input string tag);
      exp_q.push_back(e);
      tag_q.push_back(tag);
      bus_addr = a; bus_rd = 1'b1; key_valid = 1'b1; key_char = ch;
      @(negedge clk);
      bus_rd = 1'b0; key_valid = 1'b0;
   endtask

   task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input bit done);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1; disp_done = done;
      @(negedge clk);
      bus_wr = 1'b0; disp_done = 1'b0;
   endtask

   task automatic key_push(input logic [7:0] ch);
      key_valid = 1'b1; key_char = ch;
      @(negedge clk);
      key_valid = 1'b0;
   endtask

   task automatic done_pulse();
      disp_done = 1'b1;
      @(negedge clk);
      disp_done = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 kbd_irq", 32'(kbd_irq), 0);
      chk("R9 dsp_irq", 32'(dsp_irq), 0);
      chk("R9 irq", 32'(irq), 0);
      chk("R9 disp_load", 32'(disp_load), 0);
      chk("R9 rdata", 32'(bus_rdata), 0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(A_ST, stw(0,0,0,0,0), "R9 status after reset");

      key_push(8'h41);
      chk("R8 kbd_irq gated by enable", 32'(kbd_irq), 0);
      bus_read(A_ST, stw(1,0,0,0,0), "R2 input ready set");

      bus_write(A_ST, 8'hFF, 1'b0);
      chk("R8 kbd_irq", 32'(kbd_irq), 1);
      chk("R8 irq", 32'(irq), 1);
      chk("R8 dsp_irq", 32'(dsp_irq), 0);
      bus_read(A_ST, stw(1,0,1,1,0), "R7 only enables written");

      bus_read(A_KEY, 8'h41, "R3 key data");
      bus_read(A_ST, stw(0,0,1,1,0), "R3 input ready cleared");
      chk("R3 kbd_irq dropped", 32'(kbd_irq), 0);

      key_push(8'h10);
      key_push(8'h20);
      bus_read(A_ST, stw(1,0,1,1,1), "R4 overrun set");
      bus_read(A_ST, stw(1,0,1,1,0), "R4 overrun cleared by status read");
      bus_read(A_KEY, 8'h20, "R4 data overwritten");

      key_push(8'h31);
      read_with_key(A_KEY, 8'h31, 8'h32, "R3 read alongside new key");
      bus_read(A_ST, stw(1,0,1,1,0), "R3 ready kept, no overrun");
      bus_read(A_KEY, 8'h32, "R3 new key kept");

      done_pulse();
      chk("R6 dsp_irq after done", 32'(dsp_irq), 1);
      bus_read(A_ST, stw(0,1,1,1,0), "R6 output ready set");
      bus_write(A_DSP, 8'h5A, 1'b0);
      chk("R5 disp_load pulse", 32'(disp_load), 1);
      chk("R5 disp_char", 32'(disp_char), 32'h5A);
      chk("R8 dsp_irq cleared", 32'(dsp_irq), 0);
      @(negedge clk);
      chk("R5 disp_load one cycle", 32'(disp_load), 0);
      bus_read(A_ST, stw(0,0,1,1,0), "R5 output ready cleared");

      done_pulse();
      bus_write(A_DSP, 8'h77, 1'b1);
      bus_read(A_ST, stw(0,0,1,1,0), "R6 write beats done");
      bus_read(A_DSP, 8'h77, "R1 display register readback");

      bus_write(BASE + 16'd3, 8'h00, 1'b0);
      bus_write(16'h4012, 8'h00, 1'b0);
      bus_read(A_ST, stw(0,0,1,1,0), "R1 unmapped writes ignored");
      bus_read(BASE + 16'd3, 8'h00, "R1 unmapped read zero");
      bus_write(A_KEY, 8'hEE, 1'b0);
      bus_read(A_KEY, 8'h32, "R1 key register not writable");

      bus_write(A_ST, 8'h00, 1'b0);
      key_push(8'h55);
      chk("R8 irq off with enables clear", 32'(irq), 0);
      bus_read(A_ST, stw(1,0,0,0,0), "R7 enables cleared");
      bus_write(A_ST, 8'h04, 1'b0);
      chk("R8 kbd_irq on enable", 32'(kbd_irq), 1);
      bus_read(A_ST, stw(1,0,1,0,0), "R7 keyboard enable only");
      @(negedge clk);
      chk("R10 rdata holds", 32'(bus_rdata), 32'(stw(1,0,1,0,0)));

      repeat (2) @(negedge clk);
      chk("R10 scoreboard drained", 32'(exp_q.size()), 0);
      fin = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!fin) begin
         total++;
         bad++;
         $display("FAIL watchdog act=timeout exp=done");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule